// File: doc/BRIEF.md
# Audio master clock ratio generator

The block makes the audio master clock for an external converter from an on-chip reference clock. The reference comes from a synthesiser outside the block and runs at twice the serial clock rate. The serial clock itself is either 512 or 384 times the sample rate, chosen by a base-rate select bit. A 3-bit multiplier code selects a power-of-two divide of the serial clock. The same code therefore gives a master clock in the 32·fs family (32, 64, 128, 256, 512 fs) or in the 48·fs family (48, 96, 192, 384 fs), depending on the base. Sample rates from 8 kHz to 192 kHz are covered by changing the reference frequency alone.

The divider is a free-running binary counter. The output taps the counter bit that the code selects. A run enable starts and stops the output, but the internal gate only opens or closes on a cycle where the divided clock is low. Every high pulse that leaves the block is therefore full width. A code that does not exist for the chosen base raises an error flag and holds the output low. Software uses the 512·fs base for a master clock that is a multiple of 32·fs, and the 384·fs base for one that is a multiple of 48·fs.

Top module: `mclk_ratio_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mclk_o, mclk_oe_o and cfg_err_o are all 0.
- R2: With base_sel_i = 0 and code k in 0..4, mclk_o has a period of 2^(k+1) clock cycles (2^k serial clocks, i.e. 512/2^k times fs) and a 50% duty. While enabled, its value equals bit k of the number of clock edges since reset, taken modulo 32.
- R3: With base_sel_i = 1 and code k in 0..3, the divide is identical (2^(k+1) clock cycles), giving 384, 192, 96 and 48 times fs for codes 0, 1, 2 and 3.
- R4: The output gate (mclk_oe_o) opens only on a cycle where the divided clock is low and run_i is 1. It closes on the first low cycle of the divided clock after run_i falls. Once it is closed and run_i stays 0, mclk_o stays 0.
- R5: Code 4 with base_sel_i = 1, and codes 5 to 7 with either base, are illegal. One cycle after such a setting, cfg_err_o is 1 and mclk_o and mclk_oe_o are 0. A legal setting clears cfg_err_o one cycle later.
- R6: Every high pulse of mclk_o lasts exactly 2^k clock cycles, including the last pulse before a stop.
- R7: mclk_o is never 1 while mclk_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_sel_i | input | 1 | 0: serial clock at 512·fs, 1: serial clock at 384·fs |
| mult_code_i | input | 3 | Power-of-two divide code k |
| run_i | input | 1 | Run enable for the master clock output |
| mclk_o | output | 1 | Master clock output |
| mclk_oe_o | output | 1 | Output enable, high while the gate is open |
| cfg_err_o | output | 1 | Illegal base/code combination |

## Verification
The pulse-width property assumes that base_sel_i and mult_code_i change only while the output gate is closed and mclk_o is low. A change while a pulse is in flight would legitimately shorten it. The stimulus therefore drops run_i and waits until mclk_oe_o has fallen before it applies a new setting. Illegal settings are applied in the same way, so the error path never cuts a pulse. run_i itself is toggled at arbitrary phases, including in the middle of a high pulse, because the gate must absorb those toggles.

// File: rtl/mclk_gen_pkg.sv
package mclk_gen_pkg;
    parameter int unsigned CODE_W          = 3;
    parameter int unsigned MAX_CODE_WIDE   = 4;  // highest code on the 512*fs base
    parameter int unsigned MAX_CODE_NARROW = 3;  // highest code on the 384*fs base
    localparam int unsigned CNT_W          = MAX_CODE_WIDE + 1;

    typedef enum logic {
        BASE_512 = 1'b0,
        BASE_384 = 1'b1
    } base_e;

    typedef struct packed {
        logic en;
        logic mclk;
        logic err;
    } gate_state_t;
endpackage

// File: rtl/mclk_free_count.sv
module mclk_free_count #(
    parameter int unsigned W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] cnt_next_o
);
    logic [W-1:0] cnt_q;

    assign cnt_next_o = cnt_q + W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_next_o;
    end
endmodule

// File: rtl/mclk_cfg_check.sv
module mclk_cfg_check
    import mclk_gen_pkg::*;
(
    input  logic              base_sel_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o
);
    always_comb begin
        if (base_e'(base_sel_i) == BASE_384) legal_o = (code_i <= CODE_W'(MAX_CODE_NARROW));
        else                                 legal_o = (code_i <= CODE_W'(MAX_CODE_WIDE));
    end
endmodule

// File: rtl/mclk_tap_sel.sv
module mclk_tap_sel #(
    parameter int unsigned W      = 5,
    parameter int unsigned CODE_W = 3
) (
    input  logic [W-1:0]      cnt_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              legal_i,
    output logic              tap_o
);
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_tap
        assign hit[i] = (code_i == CODE_W'(i)) & cnt_i[i];
    end

    assign tap_o = legal_i & (|hit);
endmodule

// File: rtl/mclk_ratio_gen.sv
module mclk_ratio_gen
    import mclk_gen_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              base_sel_i,
    input  logic [CODE_W-1:0] mult_code_i,
    input  logic              run_i,
    output logic              mclk_o,
    output logic              mclk_oe_o,
    output logic              cfg_err_o
);
    logic [CNT_W-1:0] cnt_next;
    logic             legal;
    logic             tap_next;
    gate_state_t      st_d, st_q;

    mclk_free_count #(.W(CNT_W)) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_next_o (cnt_next)
    );

    mclk_cfg_check u_cfg (
        .base_sel_i (base_sel_i),
        .code_i     (mult_code_i),
        .legal_o    (legal)
    );

    mclk_tap_sel #(.W(CNT_W), .CODE_W(CODE_W)) u_tap (
        .cnt_i   (cnt_next),
        .code_i  (mult_code_i),
        .legal_i (legal),
        .tap_o   (tap_next)
    );

    // The gate may only move where the divided clock will be low.
    always_comb begin
        st_d     = st_q;
        st_d.err = ~legal;
        if (!tap_next) st_d.en = run_i & legal;
        st_d.mclk = st_d.en & tap_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mclk_o    = st_q.mclk;
    assign mclk_oe_o = st_q.en;
    assign cfg_err_o = st_q.err;
endmodule

// File: rtl/mclk_ratio_gen_chk.sv
module mclk_ratio_gen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       base_sel_i,
    input logic [2:0] mult_code_i,
    input logic       run_i,
    input logic       mclk_o,
    input logic       mclk_oe_o,
    input logic       cfg_err_o
);
    logic [7:0] hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hi_q <= '0;
        else if (mclk_o) hi_q <= hi_q + 8'd1;
        else             hi_q <= '0;
    end

    AST_MCLK_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclk_o |-> mclk_oe_o);  // R7
    AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (!mclk_o && !mclk_oe_o));  // R5
    AST_ERR_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_sel_i && mult_code_i == 3'd4) |=> cfg_err_o);  // R5
    AST_STAYS_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !mclk_oe_o) |=> (!mclk_oe_o && !mclk_o));  // R4
    AST_OPEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mclk_oe_o) |-> !mclk_o);  // R4
    AST_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mclk_o) |-> (hi_q == (8'd1 << $past(mult_code_i))));  // R6
endmodule

bind mclk_ratio_gen mclk_ratio_gen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_sel_i  (base_sel_i),
    .mult_code_i (mult_code_i),
    .run_i       (run_i),
    .mclk_o      (mclk_o),
    .mclk_oe_o   (mclk_oe_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_mclk_ratio_gen.sv
`timescale 1ns/1ps
module sim_mclk_ratio_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_sel = 1'b0;
    logic [2:0] code = 3'd0;
    logic       run = 1'b0;
    logic       mclk, oe, err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mclk_ratio_gen u0 (
        .clk_i(clk), .rst_ni(rst_n), .base_sel_i(base_sel), .mult_code_i(code),
        .run_i(run), .mclk_o(mclk), .mclk_oe_o(oe), .cfg_err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Behavioural reference: count edges since reset, legality from the code table.
    int m_cnt;
    bit m_en, m_mclk, m_err;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_en <= 0; m_mclk <= 0; m_err <= 0;
        end else begin
            int nc;
            bit lg, dv, en;
            nc = (m_cnt + 1) % 32;
            lg = base_sel ? (code <= 3) : (code <= 4);
            dv = lg ? bit'((nc >> code) & 1) : 1'b0;
            en = dv ? m_en : (run && lg);
            m_cnt <= nc; m_en <= en; m_mclk <= en && dv; m_err <= !lg;
        end
    end

    // Per-cycle comparison plus period and pulse-width measurement.
    bit prev_m = 0, have_rise = 0;
    int since = 0, hi_w = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(mclk == m_mclk, "R2 mclk vs model", mclk, m_mclk);
            chk(oe == m_en, "R4 oe vs model", oe, m_en);
            chk(err == m_err, "R5 err vs model", err, m_err);
            chk(!(mclk && !oe), "R7 mclk without oe", mclk, 0);
            since++;
            if (mclk && !prev_m) begin
                if (have_rise)
                    chk(since == (2 << code), base_sel ? "R3 period" : "R2 period",
                        since, 2 << code);
                have_rise = 1; since = 0;
            end
            if (!oe) have_rise = 0;
            if (mclk) hi_w++;
            else begin
                if (prev_m) chk(hi_w == (1 << code), "R6 high width", hi_w, 1 << code);
                hi_w = 0;
            end
            prev_m = mclk;
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(4);
        chk(mclk == 0, "R1 reset mclk", mclk, 0);
        chk(oe == 0, "R1 reset oe", oe, 0);
        chk(err == 0, "R1 reset err", err, 0);
        rst_n = 1'b1;
        cycles(1);
        chk(mclk == 0 && oe == 0 && err == 0, "R1 first cycle", {mclk, oe, err}, 0);

        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c <= (b ? 3 : 4); c++) begin
                base_sel = b[0]; code = 3'(c);
                cycles(3);
                run = 1'b1;
                cycles(6 * (2 << c) + 10);
                run = 1'b0;
                cycles((2 << c) + 4);
                chk(oe == 0, "R4 gate closed after stop", oe, 0);
                for (int i = 0; i < 20; i++) begin
                    chk(mclk == 0, "R4 idle after stop", mclk, 0);
                    cycles(1);
                end
            end
        end

        // stop in the middle of a high pulse
        base_sel = 1'b0; code = 3'd4;
        cycles(2);
        run = 1'b1;
        for (int i = 0; i < 100 && !mclk; i++) cycles(1);
        chk(mclk == 1, "R6 pulse seen before stop", mclk, 1);
        cycles(3);
        run = 1'b0;
        cycles(40);
        chk(oe == 0, "R4 closed after mid-pulse stop", oe, 0);

        // illegal settings
        base_sel = 1'b1; code = 3'd4; run = 1'b1;
        cycles(2);
        chk(err == 1, "R5 384 base code 4", err, 1);
        for (int i = 0; i < 40; i++) begin
            chk(mclk == 0 && oe == 0, "R5 held low", {mclk, oe}, 0);
            cycles(1);
        end
        run = 1'b0; base_sel = 1'b0; code = 3'd5; run = 1'b1;
        cycles(2);
        chk(err == 1, "R5 512 base code 5", err, 1);
        cycles(30);
        chk(mclk == 0, "R5 code 5 silent", mclk, 0);
        run = 1'b0; base_sel = 1'b1; code = 3'd7;
        cycles(2);
        chk(err == 1, "R5 code 7", err, 1);
        code = 3'd2;
        cycles(2);
        chk(err == 0, "R5 cleared by legal code", err, 0);
        cycles(10);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule